// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit operands and an incoming carry in a single combinational pass. The operands are split into four 4-bit slices. Each slice forms a generate term (AND of the bit pair) and a propagate term (OR of the bit pair) for every bit. From these it works out each internal carry as a flat sum of products taken from the slice's carry-in, instead of handing a carry from bit to bit. Each slice also reduces its bits to one group generate and one group propagate.

A second-level lookahead unit combines the four group pairs and the carry-in, using the same equation shape. It delivers the carry into every slice and the final carry-out. Sum bits are the XOR of both operand bits and the carry entering that bit. Signed overflow compares the carry into the top bit with the carry out of it. The block is meant as an integer datapath adder where the carry path must stay shallow.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `opa_i + opb_i + cin_i`, taken as unsigned numbers.
- R2: `cout_o` equals bit 16 of the 17-bit unsigned total `opa_i + opb_i + cin_i`.
- R3: `ovf_o` is 1 exactly when `opa_i[15]` equals `opb_i[15]` and `sum_o[15]` differs from them. This is two's-complement overflow.
- R4: All ones plus one gives `sum_o` = 0x0000, `cout_o` = 1 and `ovf_o` = 0. This holds both for 0xFFFF + 0x0001 with carry-in 0 and for 0xFFFF + 0x0000 with carry-in 1.
- R5: With `opa_i` = 0xFFFF and `opb_i` = 0x0000, the carry-in passes through all four slices, so `cout_o` equals `cin_i`.
- R6: A slice whose two operand nibbles are both 0xF produces a carry into the next slice whatever its own carry-in is. A slice whose two nibbles are both 0x0 passes no carry onward. Nibble k is bits 4k+3 down to 4k.
- R7: Each nibble k of `sum_o` equals the low 4 bits of (nibble k of `opa_i`) + (nibble k of `opb_i`) + c. Here c is the carry out of the sum of all lower bit positions together with `cin_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
A wrong group generate or group propagate from a slice, or a wrong term in the second-level unit, shows up at once. It appears as a sum nibble off by one at the slice boundary it feeds, often with a wrong carry-out. There is no state, so no error can stay hidden across vectors. The nibble-boundary vectors are chosen so that each slice is made, in turn, to generate, propagate and kill. A fault in the carry into bit 15 shows up as a wrong overflow flag even when the carry-out is right. The overflow corners therefore hit each sign combination.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned LA_MAX = 8;

  typedef logic [LA_MAX-1:0] la_vec_t;
  typedef logic [LA_MAX:0]   la_carry_t;

  typedef struct packed {
    logic gen;
    logic prop;
  } grp_sig_t;

  // Carry into each position i (0..n) as a flat sum of products:
  // c[i] = c0 & p[0..i-1]  |  OR over j<i of g[j] & p[j+1..i-1]
  function automatic la_carry_t lookahead(input la_vec_t g, input la_vec_t p,
                                          input logic c0, input int unsigned n);
    la_carry_t c;
    c    = '0;
    c[0] = c0;
    for (int i = 1; i <= LA_MAX; i++) begin
      if (i <= n) begin
        logic term;
        logic acc;
        term = c0;
        for (int k = 0; k < LA_MAX; k++) begin
          if (k < i) term = term & p[k];
        end
        acc = term;
        for (int j = 0; j < LA_MAX; j++) begin
          if (j < i) begin
            term = g[j];
            for (int k = 0; k < LA_MAX; k++) begin
              if (k > j && k < i) term = term & p[k];
            end
            acc = acc | term;
          end
        end
        c[i] = acc;
      end
    end
    return c;
  endfunction

  // Group generate: some position generates and every higher one propagates.
  function automatic logic group_gen(input la_vec_t g, input la_vec_t p,
                                     input int unsigned n);
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < LA_MAX; j++) begin
      if (j < n) begin
        logic term;
        term = g[j];
        for (int k = 0; k < LA_MAX; k++) begin
          if (k > j && k < n) term = term & p[k];
        end
        acc = acc | term;
      end
    end
    return acc;
  endfunction

  // Group propagate: every position propagates.
  function automatic logic group_prop(input la_vec_t p, input int unsigned n);
    logic acc;
    acc = 1'b1;
    for (int k = 0; k < LA_MAX; k++) begin
      if (k < n) acc = acc & p[k];
    end
    return acc;
  endfunction

endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          c_i,
  output logic [SW-1:0] s_o,
  output logic [SW-1:0] bit_cin_o,
  output logic          local_cout_o,
  output grp_sig_t      grp_o
);

  la_vec_t   g_ext;
  la_vec_t   p_ext;
  la_carry_t carries;

  always_comb begin
    g_ext = '0;
    p_ext = '0;
    g_ext[SW-1:0] = a_i & b_i;
    p_ext[SW-1:0] = a_i | b_i;
    carries       = lookahead(g_ext, p_ext, c_i, SW);
    bit_cin_o     = carries[SW-1:0];
    local_cout_o  = carries[SW];
    s_o           = a_i ^ b_i ^ carries[SW-1:0];
    grp_o.gen     = group_gen(g_ext, p_ext, SW);
    grp_o.prop    = group_prop(p_ext, SW);
  end

endmodule

// File: rtl/cla_group_unit.sv
module cla_group_unit
  import cla_pkg::*;
#(
  parameter int unsigned NS = 4
) (
  input  grp_sig_t [NS-1:0] grp_i,
  input  logic              c_i,
  output logic [NS:0]       slice_c_o
);

  la_vec_t   gg;
  la_vec_t   pp;
  la_carry_t carries;

  always_comb begin
    gg = '0;
    pp = '0;
    for (int k = 0; k < int'(NS); k++) begin
      gg[k] = grp_i[k].gen;
      pp[k] = grp_i[k].prop;
    end
    carries   = lookahead(gg, pp, c_i, NS);
    slice_c_o = carries[NS:0];
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SLICE_W = 4
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int unsigned NUM_SLICES = WIDTH / SLICE_W;

  // Named internal events, observed by the bound checker.
  grp_sig_t [NUM_SLICES-1:0] grp_sig;
  logic [NUM_SLICES:0]       slice_cin;
  logic [NUM_SLICES-1:0]     slice_cout_local;
  logic [WIDTH:0]            carry_vec;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    logic [SLICE_W-1:0] bit_cin;
    cla_slice #(.SW(SLICE_W)) u_slice (
      .a_i          (opa_i[k*SLICE_W +: SLICE_W]),
      .b_i          (opb_i[k*SLICE_W +: SLICE_W]),
      .c_i          (slice_cin[k]),
      .s_o          (sum_o[k*SLICE_W +: SLICE_W]),
      .bit_cin_o    (bit_cin),
      .local_cout_o (slice_cout_local[k]),
      .grp_o        (grp_sig[k])
    );
    assign carry_vec[k*SLICE_W +: SLICE_W] = bit_cin;
  end

  cla_group_unit #(.NS(NUM_SLICES)) u_grp (
    .grp_i     (grp_sig),
    .c_i       (cin_i),
    .slice_c_o (slice_cin)
  );

  assign carry_vec[WIDTH] = slice_cin[NUM_SLICES];
  assign cout_o           = slice_cin[NUM_SLICES];
  assign ovf_o            = carry_vec[WIDTH] ^ carry_vec[WIDTH-1];

endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SLICE_W = 4,
  localparam int unsigned NS     = WIDTH / SLICE_W
) (
  input logic [WIDTH-1:0]     opa_i,
  input logic [WIDTH-1:0]     opb_i,
  input logic                 cin_i,
  input logic [WIDTH-1:0]     sum_o,
  input logic                 cout_o,
  input logic                 ovf_o,
  input grp_sig_t [NS-1:0]    grp_sig,
  input logic [NS:0]          slice_cin,
  input logic [NS-1:0]        slice_cout_local
);

  always_comb begin
    logic [WIDTH:0] ref_total;
    ref_total = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, cin_i};

    assert_sum_R1: assert (sum_o == ref_total[WIDTH-1:0])
      else $error("sum mismatch");
    assert_cout_R2: assert (cout_o == ref_total[WIDTH])
      else $error("carry-out mismatch");
    assert_no_overflow_R3: assert (ovf_o == ((opa_i[WIDTH-1] == opb_i[WIDTH-1]) &&
                                             (sum_o[WIDTH-1] != opa_i[WIDTH-1])))
      else $error("overflow flag mismatch");

    for (int k = 0; k < int'(NS); k++) begin
      assert_grp_gen_R6: assert (!grp_sig[k].gen || slice_cin[k+1])
        else $error("group generate did not carry");
      assert_grp_kill_R6: assert (grp_sig[k].prop || grp_sig[k].gen || !slice_cin[k+1])
        else $error("killed group still carried");
      assert_slice_carry_R7: assert (slice_cout_local[k] == slice_cin[k+1])
        else $error("slice and second level disagree");
    end
  end

endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_chk (
  .opa_i            (opa_i),
  .opb_i            (opb_i),
  .cin_i            (cin_i),
  .sum_o            (sum_o),
  .cout_o           (cout_o),
  .ovf_o            (ovf_o),
  .grp_sig          (grp_sig),
  .slice_cin        (slice_cin),
  .slice_cout_local (slice_cout_local)
);

// File: tb/sim_cla_adder16.sv
`timescale 1ns/1ps
module sim_cla_adder16;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         ci;
  logic [W-1:0] s;
  logic         co, ov;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           finished = 1'b0;

  always #4 clk = ~clk;

  cla_adder16 u0 (
    .opa_i (a), .opb_i (b), .cin_i (ci),
    .sum_o (s), .cout_o (co), .ovf_o (ov)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h ci=%0b act=%h exp=%h", tag, a, b, ci, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(negedge clk);
    a  = va;
    b  = vb;
    ci = vc;
    #1;
  endtask

  // Full behavioural check of R1, R2 and R3 for the current vector.
  task automatic check_all(input string tag);
    logic [W:0] tot;
    logic       oexp;
    tot  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    oexp = (a[W-1] == b[W-1]) && (tot[W-1] != a[W-1]);
    chk({tag, " R1 sum"}, 32'(s), 32'(tot[W-1:0]));
    chk({tag, " R2 cout"}, 32'(co), 32'(tot[W]));
    chk({tag, " R3 ovf"}, 32'(ov), 32'(oexp));
  endtask

  task automatic t_zero;
    drive('0, '0, 1'b0);
    chk("zero R1", 32'(s), 32'h0);
    chk("zero R2", 32'(co), 32'h0);
    chk("zero R3", 32'(ov), 32'h0);
  endtask

  task automatic t_all_ones_plus_one;
    drive(16'hFFFF, 16'h0001, 1'b0);
    chk("R4 ffff+1 sum", 32'(s), 32'h0);
    chk("R4 ffff+1 cout", 32'(co), 32'h1);
    chk("R4 ffff+1 ovf", 32'(ov), 32'h0);
    drive(16'hFFFF, 16'h0000, 1'b1);
    chk("R4 ffff+cin sum", 32'(s), 32'h0);
    chk("R4 ffff+cin cout", 32'(co), 32'h1);
    chk("R4 ffff+cin ovf", 32'(ov), 32'h0);
  endtask

  task automatic t_full_propagate;
    for (int c = 0; c < 2; c++) begin
      drive(16'hFFFF, 16'h0000, c[0]);
      chk("R5 cout follows cin", 32'(co), 32'(c));
      chk("R5 sum", 32'(s), (c == 1) ? 32'h0 : 32'hFFFF);
    end
  endtask

  task automatic t_overflow_corners;
    drive(16'h7FFF, 16'h0001, 1'b0);
    chk("R3 pos+pos ovf", 32'(ov), 32'h1);
    chk("R2 pos+pos cout", 32'(co), 32'h0);
    drive(16'h8000, 16'h8000, 1'b0);
    chk("R3 neg+neg ovf", 32'(ov), 32'h1);
    chk("R2 neg+neg cout", 32'(co), 32'h1);
    chk("R1 neg+neg sum", 32'(s), 32'h0);
    drive(16'h8000, 16'hFFFF, 1'b0);
    chk("R3 min-1 ovf", 32'(ov), 32'h1);
    drive(16'h7FFF, 16'h8000, 1'b1);
    chk("R3 mixed ovf", 32'(ov), 32'h0);
    chk("R2 mixed cout", 32'(co), 32'h1);
    drive(16'h7FFF, 16'h7FFF, 1'b1);
    check_all("R3 max+max+1");
  endtask

  // Each slice in turn generates (F+F) or kills (0+0) regardless of lower bits.
  task automatic t_slice_boundaries;
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < 2; c++) begin
        logic [W-1:0] m;
        logic [3:0]   nib;
        m = 16'hF << (4 * k);
        drive(m, m, c[0]);
        nib = s[4*(k+1) +: 4];
        chk("R6 generate carries into next slice", 32'(nib), 32'h1);
        drive(~m & 16'h5555, ~m & 16'h2AAA, c[0]);
        nib = s[4*(k+1) +: 4];
        chk("R6 kill blocks next slice", 32'(nib),
            32'(((~m & 16'h5555) >> (4*(k+1))) & 4'hF) + 32'(((~m & 16'h2AAA) >> (4*(k+1))) & 4'hF) & 32'hF);
      end
    end
  endtask

  task automatic nibble_check(input string tag);
    for (int k = 0; k < W/4; k++) begin
      logic [W:0] lo_a, lo_b, lo_t;
      logic [4:0] fexp;
      lo_a = {1'b0, a} & ((17'h1 << (4*k)) - 17'h1);
      lo_b = {1'b0, b} & ((17'h1 << (4*k)) - 17'h1);
      lo_t = lo_a + lo_b + {{W{1'b0}}, ci};
      fexp = {1'b0, a[4*k +: 4]} + {1'b0, b[4*k +: 4]} + {4'b0, lo_t[4*k]};
      chk({tag, " R7 nibble"}, 32'(s[4*k +: 4]), 32'(fexp[3:0]));
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom));
      check_all("random");
      if (i % 10 == 0) nibble_check("random");
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (2) @(negedge clk);
    t_zero();
    t_all_ones_plus_one();
    t_full_propagate();
    t_overflow_corners();
    t_slice_boundaries();
    drive(16'h0FF0, 16'h00F1, 1'b1);
    nibble_check("mixed");
    t_random();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule